// File: doc/BRIEF.md
# UART Receiver Idle Timeout Detector

This block watches the receive side of a UART for silence after a character has arrived. Software uses it to find the end of a frame of unknown length. A character-received pulse loads a down-counter with a programmed 16-bit bit-period count. The counter steps down once for each bit-period strobe from the baud generator. When it reaches zero, a sticky timeout flag is raised. An interrupt request follows that flag when an enable input is high.

After an expiry, software has two ways to re-arm the block:
- A start-timeout command pulse clears the flag and freezes the counter until the next character arrives.
- The flag is left set, and the next character starts a fresh countdown.

A programmed value of zero switches the feature off completely.

Top module: `uart_idle_timeout`

## Requirements
- R1: On a character-received pulse with a nonzero programmed value, the counter loads the full 16-bit value, so the flag rises after exactly that many bit-period strobes. This holds up to the largest value, 65535.
- R2: While the programmed value is zero, the timeout flag is held at 0 and no countdown runs. This holds even when characters and strobes keep arriving. A flag that was already set is cleared on the next clock.
- R3: The counter steps down only on clocks where the bit-period strobe is high. Clocks without a strobe leave the remaining count unchanged.
- R4: A character received in the middle of a countdown restarts it from the full programmed value.
- R5: The flag goes to 1 on the clock edge at which the counter steps from 1 to 0, and at no other time.
- R6: A start-timeout pulse clears the flag on the next edge and stops the countdown. No later strobe can set the flag again until a new character arrives.
- R7: After reset, the flag and the interrupt are 0 and the counter is stopped. Strobes on an idle line that has seen no character never set the flag.
- R8: Once set, the flag stays at 1 through any number of further strobes and characters until a start-timeout pulse clears it. The counter holds at zero and does not wrap.
- R9: When a character pulse and a bit-period strobe fall in the same clock, the reload wins over the decrement.
- R10: The interrupt output is 1 exactly when the flag is 1 and the interrupt enable is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-clock strobe, once per bit period |
| char_rx | input | 1 | One-clock pulse when a character has been received |
| start_to | input | 1 | Start-timeout command: clears the flag and freezes the counter |
| timeout_val | input | 16 | Programmed timeout in bit periods; 0 disables the feature |
| irq_en | input | 1 | Interrupt enable |
| timeout_flag | output | 1 | Sticky timeout status |
| irq | output | 1 | Interrupt request: flag AND enable |

## Verification
The countdown is driven with several strobe patterns:
- Sparse strobes separated by idle clocks show that counting follows bit periods rather than clocks.
- A back-to-back strobe run to 65535 shows that the full 16-bit load is kept.
- A value of 1 covers the shortest countdown.

Each expiry test checks the flag one strobe before the expected expiry and again at it, which exposes off-by-one errors in either direction. A second character in mid-count separates a real reload from a countdown that simply continues. A character and a strobe in the same clock, placed after a partial count, tells reload priority apart from decrement priority. Idle strobes before any traffic, after a start-timeout command, and with a value of zero show whether the counter stays stopped.

// File: rtl/uart_to_pkg.sv
// Package: shared types for the UART idle timeout detector.
// Assumes a single clock domain; all strobes are one clock wide.
package uart_to_pkg;
    typedef enum logic {
        CNT_IDLE = 1'b0,
        CNT_RUN  = 1'b1
    } cnt_state_e;
endpackage

// File: rtl/uart_to_counter.sv
// Module: down-counter of bit periods with a run/idle state.
// What it does: loads the programmed value on each character, steps down on
// bit strobes while running, stops at zero and signals expiry for one clock.
// Assumes: a zero programmed value means the feature is disabled; a start
// command freezes the count until the next character.
module uart_to_counter
    import uart_to_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             char_rx,
    input  logic             start_to,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] ZERO = '0;

    cnt_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             disabled;
    logic             step;

    // Decode enable and decrement conditions.
    always_comb begin
        disabled = (load_val == ZERO);
        step     = (state == CNT_RUN) && bit_tick && !char_rx && !start_to && !disabled;
        expire_o = step && (cnt == ONE);
    end

    // Counter and run state update; reload outranks decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CNT_IDLE;
            cnt   <= ZERO;
        end else if (disabled) begin
            state <= CNT_IDLE;
        end else if (char_rx) begin
            state <= CNT_RUN;
            cnt   <= load_val;
        end else if (start_to) begin
            state <= CNT_IDLE;
        end else if (step) begin
            cnt <= cnt - ONE;
            if (cnt == ONE) begin
                state <= CNT_IDLE;
            end
        end
    end

    // R1 / R4 / R9: a character with a nonzero value loads the full value.
    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (char_rx && !disabled) |=> (cnt == $past(load_val)));

    // R3: a strobe while running above one removes exactly one.
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt > ONE) |=> (cnt == $past(cnt) - ONE));

    // R3: without a strobe or character the count does not move.
    a_r3_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_tick && !char_rx) |=> $stable(cnt));

    // R8: once at zero the count stays there until a reload.
    a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == ZERO && !char_rx) |=> (cnt == ZERO));
endmodule

// File: rtl/uart_to_status.sv
// Module: sticky timeout flag and gated interrupt.
// What it does: sets the flag on counter expiry, clears it on a start-timeout
// command or while the feature is disabled, and gates the interrupt.
// Assumes: expiry and start command never coincide (counter masks that case).
module uart_to_status (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic start_to,
    input  logic disabled,
    input  logic irq_en,
    output logic flag_o,
    output logic irq_o
);
    // Sticky flag: clear has priority, expiry sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (disabled || start_to) begin
            flag_o <= 1'b0;
        end else if (expire) begin
            flag_o <= 1'b1;
        end
    end

    // Interrupt request gating.
    always_comb begin
        irq_o = flag_o && irq_en;
    end

    // R5: the flag rises only on the clock after an expiry.
    a_r5_set_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(expire));

    // R2: a zero programmed value forces the flag low.
    a_r2_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        disabled |=> !flag_o);

    // R6: the start-timeout command clears the flag.
    a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_to |=> !flag_o);

    // R8: the flag falls only after a clear source.
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> ($past(start_to) || $past(disabled)));
endmodule

// File: rtl/uart_idle_timeout.sv
// Module: top of the UART receiver idle timeout detector.
// What it does: ties the bit-period down-counter to the sticky status flag
// and interrupt gate.
// Assumes: strobes come from the baud generator and the deserializer in
// the same clock domain, each one clock wide.
module uart_idle_timeout #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             char_rx,
    input  logic             start_to,
    input  logic [CNT_W-1:0] timeout_val,
    input  logic             irq_en,
    output logic             timeout_flag,
    output logic             irq
);
    logic expire;
    logic disabled;

    // Feature enable decode shared by both halves.
    always_comb begin
        disabled = (timeout_val == '0);
    end

    uart_to_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .char_rx  (char_rx),
        .start_to (start_to),
        .load_val (timeout_val),
        .expire_o (expire)
    );

    uart_to_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire   (expire),
        .start_to (start_to),
        .disabled (disabled),
        .irq_en   (irq_en),
        .flag_o   (timeout_flag),
        .irq_o    (irq)
    );

    // R10: the interrupt never fires while disabled by the enable input.
    a_r10_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en) |-> !irq);
endmodule

// File: tb/sim_uart_idle_timeout.sv
module sim_uart_idle_timeout;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0;
    logic        char_rx = 1'b0;
    logic        start_to = 1'b0;
    logic [15:0] timeout_val = 16'd0;
    logic        irq_en = 1'b0;
    logic        timeout_flag;
    logic        irq;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    uart_idle_timeout u0 (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .char_rx(char_rx),
        .start_to(start_to), .timeout_val(timeout_val), .irq_en(irq_en),
        .timeout_flag(timeout_flag), .irq(irq)
    );

    task automatic check(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    // One clock with the given strobes; returns at the next falling edge.
    task automatic cyc(input logic ch, input logic tk, input logic st);
        char_rx = ch; bit_tick = tk; start_to = st;
        @(negedge clk);
        char_rx = 1'b0; bit_tick = 1'b0; start_to = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            cyc(1'b0, 1'b1, 1'b0);
            cyc(1'b0, 1'b0, 1'b0);
        end
    endtask

    task automatic t_reset;
        check(timeout_flag, 1'b0, "R7 flag after reset");
        check(irq, 1'b0, "R7 irq after reset");
    endtask

    task automatic t_idle_before_traffic;
        timeout_val = 16'd3;
        ticks(50);
        check(timeout_flag, 1'b0, "R7 idle line before first char");
    endtask

    task automatic t_basic;
        timeout_val = 16'd5;
        cyc(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 20; i++) cyc(1'b0, 1'b0, 1'b0);
        check(timeout_flag, 1'b0, "R3 clocks without strobe do not count");
        ticks(4);
        check(timeout_flag, 1'b0, "R1 one strobe before expiry");
        cyc(1'b0, 1'b1, 1'b0);
        check(timeout_flag, 1'b1, "R5 flag at count zero");
    endtask

    task automatic t_sticky_irq;
        ticks(30);
        check(timeout_flag, 1'b1, "R8 flag sticky, no wrap");
        irq_en = 1'b1; #1;
        check(irq, 1'b1, "R10 irq with enable");
        irq_en = 1'b0; #1;
        check(irq, 1'b0, "R10 irq masked");
    endtask

    task automatic t_start_timeout;
        cyc(1'b0, 1'b0, 1'b1);
        check(timeout_flag, 1'b0, "R6 start command clears flag");
        ticks(20);
        check(timeout_flag, 1'b0, "R6 frozen until next char");
        cyc(1'b1, 1'b0, 1'b0);
        ticks(4);
        check(timeout_flag, 1'b0, "R6 restart from full value");
        ticks(1);
        check(timeout_flag, 1'b1, "R6 expiry after restart");
        cyc(1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_reload;
        cyc(1'b1, 1'b0, 1'b0);
        ticks(3);
        cyc(1'b1, 1'b0, 1'b0);
        ticks(4);
        check(timeout_flag, 1'b0, "R4 mid-count char restarts count");
        ticks(1);
        check(timeout_flag, 1'b1, "R4 expiry after reload");
        cyc(1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_collision;
        cyc(1'b1, 1'b0, 1'b0);
        ticks(2);
        cyc(1'b1, 1'b1, 1'b0);
        ticks(4);
        check(timeout_flag, 1'b0, "R9 reload wins over decrement");
        ticks(1);
        check(timeout_flag, 1'b1, "R9 expiry from reloaded value");
    endtask

    task automatic t_disabled;
        timeout_val = 16'd0;
        cyc(1'b0, 1'b0, 1'b0);
        check(timeout_flag, 1'b0, "R2 zero value clears set flag");
        cyc(1'b1, 1'b0, 1'b0);
        ticks(100);
        check(timeout_flag, 1'b0, "R2 disabled never times out");
    endtask

    task automatic t_min;
        timeout_val = 16'd1;
        cyc(1'b1, 1'b0, 1'b0);
        check(timeout_flag, 1'b0, "R5 no flag before first strobe");
        cyc(1'b0, 1'b1, 1'b0);
        check(timeout_flag, 1'b1, "R5 value one expires on first strobe");
        cyc(1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_max;
        timeout_val = 16'hFFFF;
        cyc(1'b1, 1'b0, 1'b0);
        bit_tick = 1'b1;
        for (int i = 0; i < 65534; i++) @(negedge clk);
        check(timeout_flag, 1'b0, "R1 max value one strobe before expiry");
        @(negedge clk);
        bit_tick = 1'b0;
        check(timeout_flag, 1'b1, "R1 max value expiry");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_before_traffic();
        t_basic();
        t_sticky_irq();
        t_start_timeout();
        t_reload();
        t_collision();
        t_disabled();
        t_min();
        t_max();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1900000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule